// File: doc/BRIEF.md
# Serial Scan Register Access Port

This block is the slave end of a four-wire serial control port that follows the IEEE 1149.1 test access port state graph. A host drives a clock, a mode-select line and a data-in line. The block returns one data-out line. The port gives access to a small bank of 8-bit configuration registers for a radio front end. Each writable register value is driven on its own parallel output. Two read-only values can also be read back: an identity byte and a 5-bit signal-strength level taken from an input.

A 6-bit instruction names the target of the next data scan. Its upper two bits give the kind of access: select, bypass or no-op. For a select instruction, the lower four bits are the register address. A single 8-bit data scan shifts the readable content of that address out while it shifts the new value in. The new value reaches the register only when the scan passes through Update-DR. The instruction stays in place after the scan, so the host can rewrite the same register with data scans alone.

The controller states are:
- Test-Logic-Reset (TLR)
- Run-Test/Idle (RTI)
- Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR and Update-DR
- Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR

The transitions are:
- From TLR, mode 0 goes to RTI.
- In RTI, mode 0 stays in RTI and mode 1 goes to Select-DR.
- From Select-DR, mode 1 goes to Select-IR and mode 0 goes to Capture-DR.
- From Select-IR, mode 1 goes to TLR and mode 0 goes to Capture-IR.
- From Capture, mode 0 goes to Shift and mode 1 goes to Exit1.
- Shift holds on mode 0 and goes to Exit1 on mode 1.
- From Exit1, mode 1 goes to Update and mode 0 goes to Pause.
- Pause holds on mode 0 and goes to Exit2 on mode 1.
- From Exit2, mode 1 goes to Update and mode 0 goes back to Shift.
- From Update, mode 1 goes to Select-DR and mode 0 goes to RTI.

Top module: `scan_reg_access`

## Requirements
- R1: The state follows the transition graph above on each rising `si_clk` edge, with `si_mode` choosing the branch. RTI holds while mode is 0, and TLR holds while mode is 1. A data scan that detours through Pause-DR still moves a total of 8 bits.
- R2: The instruction is 6 bits and is shifted least significant bit first. Capture-IR loads the value 000001, so the first six bits that leave `si_dout` during Shift-IR are 1,0,0,0,0,0.
- R3: An instruction 01YYYY selects register address YYYY. Addresses 1 to 9 (codes 17 to 25) write `cfg_vco`, `cfg_chan`, `cfg_xtrim`, `cfg_lpo_hi`, `cfg_lpo_lo`, `cfg_ctrl`, `cfg_mod`, `cfg_cur` and `cfg_en`. Their useful widths are 8, 8, 6, 1, 8, 7, 8, 3 and 8 bits. Bits above the useful width always read 0 on the port.
- R4: A data scan moves 8 bits, least significant bit first. The written register changes only on the rising edge that leaves Update-DR. Until that edge, every configuration output keeps its old value.
- R5: Readback on `si_dout` depends on the instruction code:
  - Code 16 returns the byte {0001, `ID_VER`}.
  - Code 18 returns {000, `rssi_lvl`}, sampled at Capture-DR.
  - Every other select code returns 0.
- R6: Codes 11xxxx place a 1-bit bypass stage between `si_din` and `si_dout`, loaded with 0 at Capture-DR. Bit k that comes out of a scan equals bit k-1 that went in, and bit 0 is 0.
- R7: Codes 00xxxx and 10xxxx are no-ops. A data scan under them returns all zeros and changes no output.
- R8: The instruction keeps its value across any number of data scans.
- R9: An asynchronous active-high `si_rst` forces TLR, clears the instruction to 000000 and clears every register. Entering TLR through the mode line also clears the instruction but keeps the registers.
- R10: `si_dout` changes only on falling `si_clk` edges and is 0 outside Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| si_clk | input | 1 | Serial port clock |
| si_rst | input | 1 | Asynchronous reset, active high |
| si_mode | input | 1 | Mode-select line that steers the state graph |
| si_din | input | 1 | Serial data in |
| si_dout | output | 1 | Serial data out, updated on falling edges |
| rssi_lvl | input | 5 | Signal-strength level returned by code 18 |
| cfg_vco | output | 8 | Register at address 1 |
| cfg_chan | output | 8 | Register at address 2 |
| cfg_xtrim | output | 8 | Register at address 3 (6 useful bits) |
| cfg_lpo_hi | output | 8 | Register at address 4 (1 useful bit) |
| cfg_lpo_lo | output | 8 | Register at address 5 |
| cfg_ctrl | output | 8 | Register at address 6 (7 useful bits) |
| cfg_mod | output | 8 | Register at address 7 |
| cfg_cur | output | 8 | Register at address 8 (3 useful bits) |
| cfg_en | output | 8 | Register at address 9 |

## Verification
A scan under code 18 reads the signal-strength level and writes the channel register in the same operation, so a read and a write act on one address within one scan. The sweep drives a new level and a new write byte for each instruction code. It then judges the byte that leaves `si_dout` against the level and the port against the write byte, and checks that the port keeps its old value until the Update-DR edge. Reset is also applied partway through a clock period to check that it overrides any state at once.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W     = 6;
    localparam int DR_W     = 8;
    localparam int NUM_WR   = 9;
    localparam int FIRST_WR = 1;

    localparam logic [1:0] PFX_SEL = 2'b01;
    localparam logic [1:0] PFX_BYP = 2'b11;
    localparam logic [3:0] ADDR_ID   = 4'd0;
    localparam logic [3:0] ADDR_RSSI = 4'd2;
    localparam logic [3:0] ID_CHIP   = 4'b0001;
    localparam int RSSI_W = 5;

    localparam logic [IR_W-1:0] IR_NOOP = '0;
    localparam logic [IR_W-1:0] IR_CAPT = IR_W'(1);

    function automatic int wr_width(input int idx);
        case (idx)
            2:       return 6;
            3:       return 1;
            5:       return 7;
            7:       return 3;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_TLR;
        else     state <= nxt;
    end
endmodule

// File: rtl/scan_instr.sv
module scan_instr
    import scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] ir_q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ir_sr <= '0;
            ir_q  <= IR_NOOP;
        end else begin
            unique case (state)
                ST_CAP_IR: ir_sr <= IR_CAPT;
                ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                ST_UPD_IR: ir_q  <= ir_sr;
                ST_TLR:    ir_q  <= IR_NOOP;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/scan_data_path.sv
module scan_data_path
    import scan_pkg::*;
#(
    parameter logic [3:0] ID_VER = 4'h3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  tap_state_e                   state,
    input  logic                         tdi,
    input  logic [IR_W-1:0]              ir_q,
    input  logic [RSSI_W-1:0]            rssi,
    output logic                         sel,
    output logic                         byp,
    output logic [DR_W-1:0]              dr_sr,
    output logic                         byp_q,
    output logic [NUM_WR-1:0][DR_W-1:0]  regs_q
);
    logic [3:0]      addr;
    logic [DR_W-1:0] rd_val;

    assign sel  = (ir_q[IR_W-1:IR_W-2] == PFX_SEL);
    assign byp  = (ir_q[IR_W-1:IR_W-2] == PFX_BYP);
    assign addr = ir_q[3:0];

    always_comb begin
        rd_val = '0;
        if (sel) begin
            if (addr == ADDR_ID)   rd_val = {ID_CHIP, ID_VER};
            if (addr == ADDR_RSSI) rd_val = DR_W'(rssi);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dr_sr <= '0;
            byp_q <= 1'b0;
        end else begin
            unique case (state)
                ST_CAP_DR: begin
                    if (sel) dr_sr <= rd_val;
                    if (byp) byp_q <= 1'b0;
                end
                ST_SH_DR: begin
                    if (sel) dr_sr <= {tdi, dr_sr[DR_W-1:1]};
                    if (byp) byp_q <= tdi;
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_WR; g++) begin : g_reg
        localparam int              W    = wr_width(g);
        localparam logic [DR_W-1:0] MASK = DR_W'((1 << W) - 1);
        localparam logic [3:0]      MY_A = 4'(g + FIRST_WR);
        always_ff @(posedge clk or posedge rst) begin
            if (rst)
                regs_q[g] <= '0;
            else if (state == ST_UPD_DR && sel && addr == MY_A)
                regs_q[g] <= dr_sr & MASK;
        end
    end
endmodule

// File: rtl/scan_reg_access.sv
module scan_reg_access
    import scan_pkg::*;
#(
    parameter logic [3:0] ID_VER = 4'h3
) (
    input  logic       si_clk,
    input  logic       si_rst,
    input  logic       si_mode,
    input  logic       si_din,
    output logic       si_dout,
    input  logic [4:0] rssi_lvl,
    output logic [7:0] cfg_vco,
    output logic [7:0] cfg_chan,
    output logic [7:0] cfg_xtrim,
    output logic [7:0] cfg_lpo_hi,
    output logic [7:0] cfg_lpo_lo,
    output logic [7:0] cfg_ctrl,
    output logic [7:0] cfg_mod,
    output logic [7:0] cfg_cur,
    output logic [7:0] cfg_en
);
    tap_state_e                  tap_state;
    logic [IR_W-1:0]             ir_sr, ir_q;
    logic [DR_W-1:0]             dr_sr;
    logic                        sel, byp, byp_q, dout_nxt;
    logic [NUM_WR-1:0][DR_W-1:0] regs_q;

    scan_tap_fsm i_fsm (
        .clk(si_clk), .rst(si_rst), .tms(si_mode), .state(tap_state)
    );

    scan_instr i_instr (
        .clk(si_clk), .rst(si_rst), .state(tap_state), .tdi(si_din),
        .ir_sr(ir_sr), .ir_q(ir_q)
    );

    scan_data_path #(.ID_VER(ID_VER)) i_dp (
        .clk(si_clk), .rst(si_rst), .state(tap_state), .tdi(si_din),
        .ir_q(ir_q), .rssi(rssi_lvl), .sel(sel), .byp(byp),
        .dr_sr(dr_sr), .byp_q(byp_q), .regs_q(regs_q)
    );

    always_comb begin
        dout_nxt = 1'b0;
        unique case (tap_state)
            ST_SH_IR: dout_nxt = ir_sr[0];
            ST_SH_DR: dout_nxt = sel ? dr_sr[0] : (byp ? byp_q : 1'b0);
            default:  dout_nxt = 1'b0;
        endcase
    end

    always_ff @(negedge si_clk or posedge si_rst) begin
        if (si_rst) si_dout <= 1'b0;
        else        si_dout <= dout_nxt;
    end

    assign cfg_vco    = regs_q[0];
    assign cfg_chan   = regs_q[1];
    assign cfg_xtrim  = regs_q[2];
    assign cfg_lpo_hi = regs_q[3];
    assign cfg_lpo_lo = regs_q[4];
    assign cfg_ctrl   = regs_q[5];
    assign cfg_mod    = regs_q[6];
    assign cfg_cur    = regs_q[7];
    assign cfg_en     = regs_q[8];
endmodule

// File: rtl/scan_reg_access_chk.sv
module scan_reg_access_chk
    import scan_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_q,
    input logic [IR_W-1:0] ir_sr,
    input logic [7:0]      cfg_chan
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RTI && !tms) |=> state == ST_RTI); // R1

    AST_RESET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TLR && tms) |=> state == ST_TLR); // R1

    AST_CAPTURE_IR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAP_IR) |=> ir_sr == IR_CAPT); // R2

    AST_WRITE_AT_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_chan) |-> $past(state) == ST_UPD_DR); // R4

    AST_IR_KEPT: assert property (@(posedge clk) disable iff (rst)
        !$stable(ir_q) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR)); // R8
endmodule

bind scan_reg_access scan_reg_access_chk i_chk (
    .clk(si_clk), .rst(si_rst), .tms(si_mode), .state(tap_state),
    .ir_q(ir_q), .ir_sr(ir_sr), .cfg_chan(cfg_chan)
);

// File: tb/test_scan_reg_access.sv
module test_scan_reg_access;
    logic       si_clk = 1'b0;
    logic       si_rst = 1'b1;
    logic       si_mode = 1'b1;
    logic       si_din = 1'b0;
    logic       si_dout;
    logic [4:0] rssi_lvl = 5'd0;
    logic [7:0] cfg_vco, cfg_chan, cfg_xtrim, cfg_lpo_hi, cfg_lpo_lo;
    logic [7:0] cfg_ctrl, cfg_mod, cfg_cur, cfg_en;

    localparam logic [3:0] VER = 4'h3;
    int wid [9] = '{8, 8, 6, 1, 8, 7, 8, 3, 8};
    logic [7:0] model [9];
    int n_chk = 0, n_fail = 0;

    scan_reg_access #(.ID_VER(VER)) i_scan_reg_access (.*);

    always #5 si_clk = ~si_clk;

    function automatic logic [71:0] cfg_all();
        return {cfg_vco, cfg_chan, cfg_xtrim, cfg_lpo_hi, cfg_lpo_lo,
                cfg_ctrl, cfg_mod, cfg_cur, cfg_en};
    endfunction

    function automatic logic [71:0] model_all();
        return {model[0], model[1], model[2], model[3], model[4],
                model[5], model[6], model[7], model[8]};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge si_clk); #1;
        o = si_dout;
        si_mode = m;
        si_din = d;
        @(posedge si_clk); #1;
    endtask

    task automatic ir_scan(input logic [5:0] code, output logic [5:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 6; i++) begin
            step(i == 5, code[i], o);
            cap[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic dr_scan(input logic [7:0] w, output logic [7:0] r, output logic [71:0] pre);
        logic o;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, w[i], o);
            r[i] = o;
        end
        step(1, 0, o);
        pre = cfg_all();
        step(0, 0, o);
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [5:0]  cap, code;
        logic [7:0]  r, w, exp_r;
        logic [71:0] pre, old;
        logic        o;
        for (int i = 0; i < 9; i++) model[i] = 8'h00;

        repeat (3) @(posedge si_clk);
        #2 si_rst = 1'b0;
        check("R9 reset outputs", cfg_all(), 72'h0);
        check("R10 reset dout", si_dout, 0);
        step(0, 0, o);

        // Exhaustive sweep over all instruction codes: R2 R3 R4 R5 R6 R7
        for (int c = 0; c < 64; c++) begin
            code = 6'(c);
            rssi_lvl = code[4:0] ^ 5'h15;
            ir_scan(code, cap);
            check("R2 capture pattern", cap, 6'b000001);
            w = 8'(c * 37 + 11);
            old = model_all();
            dr_scan(w, r, pre);
            if (code[5:4] == 2'b01) begin
                exp_r = 8'h00;
                if (code[3:0] == 4'd0) exp_r = {4'b0001, VER};
                if (code[3:0] == 4'd2) exp_r = {3'b000, rssi_lvl};
                check("R5 readback", r, exp_r);
                if (code[3:0] >= 1 && code[3:0] <= 9)
                    model[code[3:0]-1] = w & 8'((1 << wid[code[3:0]-1]) - 1);
                check("R3 write", cfg_all(), model_all());
            end else if (code[5:4] == 2'b11) begin
                check("R6 bypass", r, {w[6:0], 1'b0});
                check("R6 no write", cfg_all(), model_all());
            end else begin
                check("R7 noop read", r, 8'h00);
                check("R7 noop write", cfg_all(), model_all());
            end
            check("R4 held before update", pre, old);
        end

        // R8: repeated data scans without a new instruction
        ir_scan(6'd18, cap);
        rssi_lvl = 5'h0A;
        dr_scan(8'h4D, r, pre);
        check("R8 first scan", cfg_chan, 8'h4D);
        check("R5 rssi read", r, 8'h0A);
        rssi_lvl = 5'h1F;
        dr_scan(8'hA6, r, pre);
        check("R8 second scan", cfg_chan, 8'hA6);
        check("R8 rssi again", r, 8'h1F);
        model[1] = 8'hA6;

        // R10: idle output low
        step(0, 0, o); step(0, 0, o);
        check("R10 idle dout", o, 0);

        // R1: data scan with a Pause-DR detour
        w = 8'h3C;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 4; i++) step(i == 3, w[i], o);
        step(0, 0, o); step(0, 0, o); step(1, 0, o); step(0, 0, o);
        for (int i = 4; i < 8; i++) step(i == 7, w[i], o);
        step(1, 0, o); step(0, 0, o);
        check("R1 pause detour", cfg_chan, 8'h3C);
        model[1] = 8'h3C;

        // R9: mode-line reset clears instruction, keeps registers
        for (int i = 0; i < 5; i++) step(1, 0, o);
        step(0, 0, o);
        dr_scan(8'h77, r, pre);
        check("R9 TLR noop read", r, 8'h00);
        check("R9 TLR registers kept", cfg_all(), model_all());

        // R9: asynchronous reset landing mid-cycle
        @(posedge si_clk); #3;
        si_rst = 1'b1;
        #1;
        check("R9 async clear", cfg_all(), 72'h0);
        repeat (2) @(posedge si_clk);
        #2 si_rst = 1'b0;
        for (int i = 0; i < 9; i++) model[i] = 8'h00;
        step(0, 0, o);
        dr_scan(8'hFF, r, pre);
        check("R9 async noop read", r, 8'h00);
        check("R9 async noop write", cfg_all(), 72'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule